// File: doc/BRIEF.md
# Compare and Branch Unit

This block resolves conditional branches for a 32-bit processor whose instructions are 16 bits wide. A compare instruction does not set flags. It copies its two register operands into a pair of operand latches inside the unit. A later conditional branch tests those stored values against one of ten relations and selects the address of the next instruction.

The unit decodes the branch instruction word, evaluates the selected relation, and forms the target from a signed 10-bit halfword displacement. The displacement is measured from the instruction that follows the branch. A selector that names no relation is flagged as illegal, and the PC stays on the faulting instruction so that the exception logic can report it. Fetch, the register file and exception entry sit outside the block.

Top module: `cmp_branch_unit`

## Requirements
- R1: While reset is held, and after it is released, both operand latches read zero. A branch on equal is therefore taken and a branch on unsigned less-than is not taken.
- R2: When `cmp_valid` is high at a rising clock edge, the unit stores `cmp_a` into latch a and `cmp_b` into latch b. Without that strobe, both latches keep their values through any number of cycles, whatever `cmp_a` and `cmp_b` carry.
- R3: A branch is recognised only when `br_valid` is high and `br_opcode[15:14]` is 2'b11. Any other word leaves `br_taken` and `br_illegal` low and sets `next_pc` to `pc + 2`.
- R4: The displacement is `br_opcode[9:0]`, sign-extended from bit 9 and multiplied by two. A taken branch sets `next_pc` to `pc + 2 + displacement`, modulo 2^32. The field 0x1FF gives +1022 and the field 0x200 gives -1024.
- R5: A legal branch whose relation is false drives `br_taken` low and sets `next_pc` to `pc + 2`.
- R6: The selector is `br_opcode[13:10]`. Selector 0 tests a == b and selector 1 tests a != b.
- R7: Selectors 2, 3, 6 and 7 test, in two's complement, a < b, a > b, a >= b and a <= b respectively.
- R8: Selectors 4, 5, 8 and 9 test, unsigned, a < b, a > b, a >= b and a <= b respectively.
- R9: Selectors 10 to 15 drive `br_illegal` high and `br_taken` low, and hold `next_pc` equal to `pc`.
- R10: When a compare and a branch arrive in the same cycle, the branch evaluates the previously stored operands. The new operands take effect from the next cycle.
- R11: `br_taken`, `br_illegal` and `next_pc` follow their inputs combinationally, in the same cycle as `br_valid`.
- R12: With `br_valid` low, `br_taken` and `br_illegal` are low and `next_pc` is `pc + 2`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Compare instruction strobe |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_valid | input | 1 | Branch instruction strobe |
| br_opcode | input | 16 | Branch instruction word |
| pc | input | 32 | Address of the current instruction |
| next_pc | output | 32 | Address of the next instruction |
| br_taken | output | 1 | The branch relation held |
| br_illegal | output | 1 | The branch selector is undefined |

## Verification
A compare and a branch can fall in the same cycle. Whether the branch then sees the old or the new operand pair decides the program's control flow. The bench first stores an equal pair. It then presents a branch on equal together with a compare that loads an unequal pair, and expects the branch to be taken on the old values. On the next cycle it checks that an unsigned less-than branch reflects the new pair.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int XLEN   = 32;
  localparam int INSN_W = 16;
  localparam int SEL_W  = 4;

  localparam logic [SEL_W-1:0] CC_EQ  = 4'd0;
  localparam logic [SEL_W-1:0] CC_NE  = 4'd1;
  localparam logic [SEL_W-1:0] CC_LT  = 4'd2;
  localparam logic [SEL_W-1:0] CC_GT  = 4'd3;
  localparam logic [SEL_W-1:0] CC_LTU = 4'd4;
  localparam logic [SEL_W-1:0] CC_GTU = 4'd5;
  localparam logic [SEL_W-1:0] CC_GE  = 4'd6;
  localparam logic [SEL_W-1:0] CC_LE  = 4'd7;
  localparam logic [SEL_W-1:0] CC_GEU = 4'd8;
  localparam logic [SEL_W-1:0] CC_LEU = 4'd9;
  localparam logic [SEL_W-1:0] CC_LAST = CC_LEU;
endpackage

// File: rtl/cbu_operand_latch.sv
module cbu_operand_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] op_a,
  output logic [W-1:0] op_b
);
  logic [W-1:0] a_q, b_q, a_d, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (ld_en) begin
      a_d = in_a;
      b_d = in_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign op_a = a_q;
  assign op_b = b_q;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> ($stable(op_a) && $stable(op_b)));                        // R2
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (op_a == $past(in_a) && op_b == $past(in_b)));             // R2
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [SEL_W-1:0] sel,
  output logic             sel_ok,
  output logic             hit
);
  logic eq, ltu, lts;

  always_comb begin
    eq  = (op_a == op_b);
    ltu = (op_a < op_b);
    lts = ($signed(op_a) < $signed(op_b));
  end

  always_comb begin
    sel_ok = (sel <= CC_LAST);
    case (sel)
      CC_EQ:   hit = eq;
      CC_NE:   hit = !eq;
      CC_LT:   hit = lts;
      CC_GT:   hit = !lts && !eq;
      CC_LTU:  hit = ltu;
      CC_GTU:  hit = !ltu && !eq;
      CC_GE:   hit = !lts;
      CC_LE:   hit = lts || eq;
      CC_GEU:  hit = !ltu;
      CC_LEU:  hit = ltu || eq;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbu_target_gen.sv
module cbu_target_gen #(
  parameter int W     = 32,
  parameter int OFS_W = 10,
  parameter int ILEN  = 2
) (
  input  logic [W-1:0]     pc,
  input  logic [OFS_W-1:0] ofs_field,
  output logic [W-1:0]     seq_pc,
  output logic [W-1:0]     tgt_pc
);
  localparam int EXT_W = W - OFS_W - 1;
  logic [W-1:0] disp;

  always_comb begin
    disp   = {{EXT_W{ofs_field[OFS_W-1]}}, ofs_field, 1'b0};
    seq_pc = pc + W'(ILEN);
    tgt_pc = seq_pc + disp;
  end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int IW    = INSN_W,
  parameter int OFS_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_valid,
  input  logic [W-1:0]  cmp_a,
  input  logic [W-1:0]  cmp_b,
  input  logic          br_valid,
  input  logic [IW-1:0] br_opcode,
  input  logic [W-1:0]  pc,
  output logic [W-1:0]  next_pc,
  output logic          br_taken,
  output logic          br_illegal
);
  localparam int ILEN   = IW / 8;
  localparam int SEL_LO = OFS_W;
  localparam int SEL_HI = OFS_W + SEL_W - 1;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [W-1:0]     op_a, op_b, seq_pc, tgt_pc;
  logic [SEL_W-1:0] sel;
  logic             sel_ok, hit, is_branch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  cbu_operand_latch #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_core_n), .ld_en(cmp_valid),
    .in_a(cmp_a), .in_b(cmp_b), .op_a(op_a), .op_b(op_b)
  );

  assign sel = br_opcode[SEL_HI:SEL_LO];

  cbu_cond_eval #(.W(W)) u_eval (
    .op_a(op_a), .op_b(op_b), .sel(sel), .sel_ok(sel_ok), .hit(hit)
  );

  cbu_target_gen #(.W(W), .OFS_W(OFS_W), .ILEN(ILEN)) u_tgt (
    .pc(pc), .ofs_field(br_opcode[OFS_W-1:0]), .seq_pc(seq_pc), .tgt_pc(tgt_pc)
  );

  always_comb begin
    is_branch  = br_valid && (br_opcode[IW-1:IW-2] == 2'b11);
    br_illegal = is_branch && !sel_ok;
    br_taken   = is_branch && sel_ok && hit;
    if (br_illegal)    next_pc = pc;
    else if (br_taken) next_pc = tgt_pc;
    else               next_pc = seq_pc;
  end

  AST_TAKEN_EXCL: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(br_taken && br_illegal));                                          // R9
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    br_illegal |-> (next_pc == pc));                                     // R9
  AST_IDLE_SEQ: assert property (@(posedge clk) disable iff (!rst_core_n)
    !br_valid |-> (!br_taken && !br_illegal && next_pc == pc + W'(ILEN))); // R12
  AST_EQ_MATCH: assert property (@(posedge clk) disable iff (!rst_core_n)
    (br_taken && sel == CC_EQ) |-> (op_a == op_b));                      // R6
  AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_core_n)
    (is_branch && !br_taken && !br_illegal) |-> (next_pc == pc + W'(ILEN))); // R5
endmodule

// File: tb/cmp_branch_unit_test.sv
module cmp_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_valid;
  logic [31:0] cmp_a, cmp_b, pc, next_pc;
  logic        br_valid;
  logic [15:0] br_opcode;
  logic        br_taken, br_illegal;
  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  cmp_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .br_valid(br_valid), .br_opcode(br_opcode), .pc(pc),
    .next_pc(next_pc), .br_taken(br_taken), .br_illegal(br_illegal)
  );

  function automatic logic [15:0] mk(input int c, input logic [9:0] ofs);
    return {2'b11, 4'(c), ofs};
  endfunction

  function automatic bit ref_cond(input int c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) < $signed(b);
      3: return $signed(a) > $signed(b);
      4: return a < b;
      5: return a > b;
      6: return $signed(a) >= $signed(b);
      7: return $signed(a) <= $signed(b);
      8: return a >= b;
      9: return a <= b;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] p, input logic [15:0] op,
                       input bit v, input bit et, input bit ei, input logic [31:0] en);
    @(negedge clk);
    pc = p; br_opcode = op; br_valid = v;
    #1;
    tests++;
    if (br_taken !== et || br_illegal !== ei || next_pc !== en) begin
      fails++;
      $display("FAIL %s: taken=%0b illegal=%0b next=%h, expected taken=%0b illegal=%0b next=%h",
               req, br_taken, br_illegal, next_pc, et, ei, en);
    end
    br_valid = 0;
  endtask

  task automatic do_cmp(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmp_valid = 1; cmp_a = a; cmp_b = b;
    @(negedge clk);
    cmp_valid = 0; cmp_a = ~a; cmp_b = ~b;
  endtask

  task automatic t_reset();
    check("R1", 32'h100, mk(0, 10'd4), 1, 1, 0, 32'h10A);
    check("R1", 32'h100, mk(4, 10'd4), 1, 0, 0, 32'h102);
  endtask

  task automatic t_grid(input logic [31:0] a, input logic [31:0] b);
    do_cmp(a, b);
    for (int c = 0; c < 10; c++) begin
      bit t = ref_cond(c, a, b);
      string r = (c < 2) ? "R6" : ((c == 4 || c == 5 || c == 8 || c == 9) ? "R8" : "R7");
      check(r, 32'h2000, mk(c, 10'h010), 1, t, 0, t ? 32'h2022 : 32'h2002);
    end
  endtask

  task automatic t_hold();
    do_cmp(32'd3, 32'd7);
    repeat (5) @(negedge clk);
    check("R2", 32'h40, mk(4, 10'd1), 1, 1, 0, 32'h44);
    check("R5", 32'h40, mk(5, 10'd1), 1, 0, 0, 32'h42);
  endtask

  task automatic t_offsets();
    do_cmp(32'd1, 32'd1);
    check("R4", 32'h1000, mk(0, 10'h1FF), 1, 1, 0, 32'h1000 + 2 + 1022);
    check("R4", 32'h1000, mk(0, 10'h200), 1, 1, 0, 32'h1000 + 2 - 1024);
    check("R4", 32'h1000, mk(0, 10'h3FF), 1, 1, 0, 32'h1000);
    check("R4", 32'h0000_0010, mk(0, 10'h200), 1, 1, 0, 32'hFFFF_FC12);
  endtask

  task automatic t_illegal();
    for (int c = 10; c < 16; c++)
      check("R9", 32'h500, mk(c, 10'h004), 1, 0, 1, 32'h500);
  endtask

  task automatic t_form();
    check("R3", 32'h600, {2'b10, 4'd0, 10'h004}, 1, 0, 0, 32'h602);
    check("R3", 32'h600, {2'b01, 4'd12, 10'h004}, 1, 0, 0, 32'h602);
    check("R12", 32'h600, mk(0, 10'h004), 0, 0, 0, 32'h602);
    check("R12", 32'h600, mk(13, 10'h004), 0, 0, 0, 32'h602);
  endtask

  task automatic t_same_cycle();
    do_cmp(32'd5, 32'd5);
    @(negedge clk);
    cmp_valid = 1; cmp_a = 32'd1; cmp_b = 32'd9;
    pc = 32'h800; br_opcode = mk(0, 10'd2); br_valid = 1;
    #1;
    tests++;
    if (br_taken !== 1'b1 || next_pc !== 32'h806) begin
      fails++;
      $display("FAIL R10: taken=%0b next=%h, expected taken=1 next=00000806", br_taken, next_pc);
    end
    @(negedge clk);
    cmp_valid = 0; br_valid = 0;
    check("R10", 32'h800, mk(4, 10'd2), 1, 1, 0, 32'h806);
  endtask

  task automatic t_comb();
    do_cmp(32'd2, 32'd2);
    @(negedge clk);
    pc = 32'h900; br_opcode = mk(1, 10'd8); br_valid = 1;
    #1;
    tests++;
    if (br_taken !== 1'b0 || next_pc !== 32'h902) begin
      fails++;
      $display("FAIL R11: taken=%0b next=%h, expected taken=0 next=00000902", br_taken, next_pc);
    end
    br_opcode = mk(0, 10'd8);
    #1;
    tests++;
    if (br_taken !== 1'b1 || next_pc !== 32'h912) begin
      fails++;
      $display("FAIL R11: taken=%0b next=%h, expected taken=1 next=00000912", br_taken, next_pc);
    end
    br_valid = 0;
  endtask

  initial begin
    rst_n = 0; cmp_valid = 0; cmp_a = 0; cmp_b = 0;
    br_valid = 0; br_opcode = 0; pc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hold();
    t_grid(32'd10, 32'd20);
    t_grid(32'd20, 32'd10);
    t_grid(32'hFFFF_FFFF, 32'd1);
    t_grid(32'd1, 32'h8000_0000);
    t_grid(32'h1234_5678, 32'h1234_5678);
    t_offsets();
    t_illegal();
    t_form();
    t_same_cycle();
    t_comb();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule